// File: doc/BRIEF.md
# Multi-Identifier Codeword Matcher

This block checks each received 32-bit paging codeword against a table of six programmable identifiers and one fixed standard sync word. It reports whether a match occurred, which identifier matched (1 to 7), and the kind of that identifier. Each slot can be a user address, a user-programmable sync word, a batch-zero marker or a continuous-data sync word. The table sits upstream of message decoding and works on codewords after bit-sync recovery and error correction.

The table is loaded through a byte-wide write port laid out as three rows of six columns. Column `c` of rows one, two and three sits at byte addresses `0x10+c`, `0x18+c` and `0x20+c`. Each slot has an enable input. Two feature-enable inputs gate recognition of batch-zero markers and continuous-data sync words. Slots 1 and 2 may act only as user addresses or batch-zero markers.

Top module: `codeword_id_matcher`

## Requirements
- R1: A write with `cfg_wr` high to address `0x10+c`, `0x18+c` or `0x20+c` (c = 0..5) stores `cfg_wdata` as byte one, two or three of slot c+1. A write to any other address changes no slot.
- R2: A table hit reports `res_id` equal to the column number plus one (1..6).
- R3: A slot whose `slot_en[c]` bit is low never produces a match.
- R4: A codeword exactly equal to 32'h7CD215D8 always matches as identifier 7 with kind 01 when no table slot matches.
- R5: The slot kind is {byte3 bit 2, byte3 bit 0}. The codes are 00 user address, 01 programmable sync word, 10 batch-zero marker and 11 continuous-data sync word. `res_kind` reports this code.
- R6: Slots 1 and 2 never match while their kind code is 01 or 11.
- R7: A slot of kind 10 matches only while `en_batch0` is high.
- R8: A slot of kind 11 matches only while `en_cont` is high.
- R9: A slot compares the pattern {byte1, byte2, byte3 bits 7..3, byte3 bit 1} against codeword bits 31..10. Codeword bits 9..0 are ignored.
- R10: When several identifiers match, the lowest identifier number is reported. The fixed sync word is identifier 7, so every table slot has priority over it.
- R11: The result appears on the clock edge after the edge that samples `cw_vld` high. `res_vld` is high for one cycle per strobe. When there is no hit, `res_id` and `res_kind` are zero.
- R12: A synchronous active-low reset clears all outputs and every stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Table byte write strobe |
| cfg_addr | input | 8 | Table byte address |
| cfg_wdata | input | 8 | Table byte data |
| slot_en | input | 6 | Per-slot enable, bit c for identifier c+1 |
| en_batch0 | input | 1 | Allows batch-zero marker matches |
| en_cont | input | 1 | Allows continuous-data sync matches |
| cw_vld | input | 1 | Codeword valid strobe |
| cw_data | input | 32 | Received codeword |
| res_vld | output | 1 | Result valid, one cycle per strobe |
| res_hit | output | 1 | An identifier matched |
| res_id | output | 3 | Matched identifier number, 0 on miss |
| res_kind | output | 2 | Kind code of matched identifier, 0 on miss |

## Verification
The bench loads slot 5 with the same pattern as slot 1 and then disables slot 1. A design with the wrong priority or broken enables reports the wrong number. Slot 6 is later given the pattern of the standard sync word, so a design that favours the fixed sync reports 7 instead of 6. Slot 2 is reloaded with the forbidden codes 01 and 11 to catch a design that ignores the position restriction. The feature gates are toggled around batch-zero and continuous-data slots, and junk low codeword bits and writes to unmapped addresses expose decode or mask errors.

// File: rtl/cwm_pkg.sv
// Shared types and constants for the codeword identifier matcher.
package cwm_pkg;
    localparam int          PAT_W    = 22;
    localparam logic [31:0] STD_SYNC = 32'h7CD215D8;

    typedef enum logic [1:0] {
        KIND_ADDR   = 2'b00,
        KIND_USYNC  = 2'b01,
        KIND_BATCH0 = 2'b10,
        KIND_CONT   = 2'b11
    } kind_e;

    typedef struct packed {
        logic [PAT_W-1:0] pat;
        kind_e            kind;
    } entry_t;
endpackage

// File: rtl/cwm_table.sv
// Identifier table: three byte rows by NUM_SLOTS columns, written one byte
// at a time. Each slot's bytes are decoded into a pattern and a kind.
// Assumes the row bases and stride keep rows from overlapping.
module cwm_table
    import cwm_pkg::*;
#(
    parameter int NUM_SLOTS  = 6,
    parameter int ADDR_W     = 8,
    parameter int ROW_BASE   = 16,
    parameter int ROW_STRIDE = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [7:0]             wr_data,
    output entry_t [NUM_SLOTS-1:0] entries
);
    localparam int ROWS = 3;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [7:0] bytes_q [ROWS];

        for (genvar r = 0; r < ROWS; r++) begin : g_row
            localparam int BYTE_ADDR = ROW_BASE + r * ROW_STRIDE + s;
            // Store one table byte when its own address is written.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bytes_q[r] <= '0;
                else if (wr_en && wr_addr == ADDR_W'(BYTE_ADDR))
                    bytes_q[r] <= wr_data;
            end
        end

        // Split the stored bytes into the compare pattern and the kind code.
        always_comb begin
            entries[s].pat  = {bytes_q[0], bytes_q[1], bytes_q[2][7:3], bytes_q[2][1]};
            entries[s].kind = kind_e'({bytes_q[2][2], bytes_q[2][0]});
        end
    end

    // A row-one write to column 0 lands in the top pattern byte of slot 1.
    p_row_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(ROW_BASE)) |=> entries[0].pat[PAT_W-1 -: 8] == $past(wr_data));
endmodule

// File: rtl/cwm_slot_cmp.sv
// One slot comparator. It decides whether the slot's kind is allowed at its
// position and under the feature gates, then compares the pattern.
// Assumes word_hi already carries codeword bits 31..10.
module cwm_slot_cmp
    import cwm_pkg::*;
#(
    parameter bit RESTRICTED = 1'b0
) (
    input  entry_t           entry,
    input  logic             enable,
    input  logic [PAT_W-1:0] word_hi,
    input  logic             en_batch0,
    input  logic             en_cont,
    output logic             hit
);
    logic allowed;

    // Decide whether this kind may be recognised in this slot right now.
    always_comb begin
        unique case (entry.kind)
            KIND_ADDR:   allowed = 1'b1;
            KIND_USYNC:  allowed = !RESTRICTED;
            KIND_BATCH0: allowed = en_batch0;
            KIND_CONT:   allowed = !RESTRICTED && en_cont;
            default:     allowed = 1'b0;
        endcase
    end

    // Report a hit for an enabled, allowed slot whose pattern matches.
    always_comb hit = enable && allowed && (entry.pat == word_hi);
endmodule

// File: rtl/cwm_pick.sv
// Priority picker and result register. The lowest-numbered slot hit wins.
// The fixed sync word is the last candidate. Results are registered on the
// strobe edge.
module cwm_pick
    import cwm_pkg::*;
#(
    parameter int NUM_SLOTS = 6,
    parameter int ID_W      = $clog2(NUM_SLOTS + 2)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   strobe,
    input  logic [NUM_SLOTS-1:0]   slot_hit,
    input  entry_t [NUM_SLOTS-1:0] entries,
    input  logic                   sync_hit,
    output logic                   res_vld,
    output logic                   res_hit,
    output logic [ID_W-1:0]        res_id,
    output logic [1:0]             res_kind
);
    localparam int SYNC_ID = NUM_SLOTS + 1;

    logic            nxt_hit;
    logic [ID_W-1:0] nxt_id;
    logic [1:0]      nxt_kind;

    // Walk from the highest slot down so that the lowest hit is written last.
    always_comb begin
        nxt_hit  = sync_hit;
        nxt_id   = sync_hit ? ID_W'(SYNC_ID) : '0;
        nxt_kind = sync_hit ? KIND_USYNC : KIND_ADDR;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (slot_hit[s]) begin
                nxt_hit  = 1'b1;
                nxt_id   = ID_W'(s + 1);
                nxt_kind = entries[s].kind;
            end
        end
    end

    // Register the result for one cycle per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld  <= 1'b0;
            res_hit  <= 1'b0;
            res_id   <= '0;
            res_kind <= '0;
        end else begin
            res_vld  <= strobe;
            res_hit  <= strobe && nxt_hit;
            res_id   <= strobe ? nxt_id : '0;
            res_kind <= strobe ? nxt_kind : '0;
        end
    end

    // A reported hit always carries a real identifier number.
    p_hit_has_id_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> (res_id != '0 && res_id <= ID_W'(SYNC_ID)));
endmodule

// File: rtl/codeword_id_matcher.sv
// Top level: identifier table, one comparator per slot, a fixed sync-word
// comparator and the priority result register. Assumes each codeword is
// already corrected, and that slot_en and the feature gates are stable at
// the strobe.
module codeword_id_matcher
    import cwm_pkg::*;
#(
    parameter int NUM_SLOTS  = 6,
    parameter int RESTRICT_N = 2,
    parameter int ADDR_W     = 8,
    parameter int ID_W       = $clog2(NUM_SLOTS + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [7:0]           cfg_wdata,
    input  logic [NUM_SLOTS-1:0] slot_en,
    input  logic                 en_batch0,
    input  logic                 en_cont,
    input  logic                 cw_vld,
    input  logic [31:0]          cw_data,
    output logic                 res_vld,
    output logic                 res_hit,
    output logic [ID_W-1:0]      res_id,
    output logic [1:0]           res_kind
);
    localparam int SYNC_ID = NUM_SLOTS + 1;

    entry_t [NUM_SLOTS-1:0] entries;
    logic   [NUM_SLOTS-1:0] slot_hit;
    logic   [PAT_W-1:0]     word_hi;
    logic                   sync_hit;

    cwm_table #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .entries (entries)
    );

    // Take the address/sync content bits of the codeword.
    always_comb word_hi = cw_data[31 -: PAT_W];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
        cwm_slot_cmp #(.RESTRICTED(s < RESTRICT_N)) u_cmp (
            .entry     (entries[s]),
            .enable    (slot_en[s]),
            .word_hi   (word_hi),
            .en_batch0 (en_batch0),
            .en_cont   (en_cont),
            .hit       (slot_hit[s])
        );
    end

    // The built-in sync word compares all 32 bits and is always enabled.
    always_comb sync_hit = (cw_data == STD_SYNC);

    cwm_pick #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (cw_vld),
        .slot_hit (slot_hit),
        .entries  (entries),
        .sync_hit (sync_hit),
        .res_vld  (res_vld),
        .res_hit  (res_hit),
        .res_id   (res_id),
        .res_kind (res_kind)
    );

    // A hit is only reported alongside a valid result.
    p_hit_needs_vld_r11: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_vld);
    // A miss reports zero number and kind.
    p_miss_is_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_hit) |-> (res_id == '0 && res_kind == 2'b00));
    // Identifier 7 is reported only for the exact fixed sync word.
    p_sync_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_hit && res_id == ID_W'(SYNC_ID)) |-> $past(cw_data) == STD_SYNC);
    // Restricted positions never report the forbidden kinds.
    p_restricted_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_hit && res_id != '0 && res_id <= ID_W'(RESTRICT_N)) |-> !res_kind[0]);
    // Batch-zero matches need the gate at the strobe.
    p_batch0_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_hit && res_kind == 2'b10) |-> $past(en_batch0));
    // Continuous-data matches need the gate at the strobe.
    p_cont_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_hit && res_kind == 2'b11) |-> $past(en_cont));
endmodule

// File: tb/codeword_id_matcher_bench.sv
module codeword_id_matcher_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [5:0]  slot_en = 6'b011111;
    logic        en_batch0 = 1'b0;
    logic        en_cont = 1'b0;
    logic        cw_vld = 1'b0;
    logic [31:0] cw_data = '0;
    logic        res_vld, res_hit;
    logic [2:0]  res_id;
    logic [1:0]  res_kind;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    localparam logic [21:0] PA = 22'h2A5A5, PB = 22'h1C3F0, PC = 22'h3F00F,
                            PD = 22'h05555, PE = 22'h12345, PS = 22'h1F3485;
    localparam logic [31:0] SYNC = 32'h7CD215D8;

    always #5 clk = ~clk;

    codeword_id_matcher u_codeword_id_matcher (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .slot_en(slot_en), .en_batch0(en_batch0),
        .en_cont(en_cont), .cw_vld(cw_vld), .cw_data(cw_data),
        .res_vld(res_vld), .res_hit(res_hit), .res_id(res_id), .res_kind(res_kind)
    );

    // Vector: codeword, en_batch0, en_cont, expected hit, id, kind.
    localparam int NV = 12;
    localparam logic [39:0] VEC [NV] = '{
        {PA, 10'h000, 1'b0, 1'b0, 1'b1, 3'd1, 2'b00},  // R2 R5 slot 1
        {PA, 10'h3FF, 1'b0, 1'b0, 1'b1, 3'd1, 2'b00},  // R9 low bits ignored
        {PB, 10'h155, 1'b0, 1'b0, 1'b0, 3'd0, 2'b00},  // R7 gate off
        {PB, 10'h155, 1'b1, 1'b0, 1'b1, 3'd2, 2'b10},  // R7 gate on
        {PC, 10'h0AA, 1'b0, 1'b0, 1'b1, 3'd3, 2'b01},  // R5 prog sync
        {PD, 10'h001, 1'b0, 1'b0, 1'b0, 3'd0, 2'b00},  // R8 gate off
        {PD, 10'h001, 1'b0, 1'b1, 1'b1, 3'd4, 2'b11},  // R8 gate on
        {PE, 10'h000, 1'b1, 1'b1, 1'b0, 3'd0, 2'b00},  // R3 slot 6 disabled
        {SYNC,        1'b0, 1'b0, 1'b1, 3'd7, 2'b01},  // R4 sync
        {SYNC ^ 32'h1, 1'b0, 1'b0, 1'b0, 3'd0, 2'b00}, // R4 one bit off
        {PA ^ 22'h1, 10'h000, 1'b0, 1'b0, 1'b0, 3'd0, 2'b00}, // R9 pattern bit 10
        {32'h0,       1'b1, 1'b1, 1'b0, 3'd0, 2'b00}   // R11 miss zeros
    };

    task automatic check(input string tag, input logic ah, input logic [2:0] ai,
                         input logic [1:0] ak, input logic eh, input logic [2:0] ei,
                         input logic [1:0] ek);
        n_chk++;
        if (ah !== eh || ai !== ei || ak !== ek) begin
            n_bad++;
            $display("FAIL %s: got hit=%0d id=%0d kind=%0d, want hit=%0d id=%0d kind=%0d",
                     tag, ah, ai, ak, eh, ei, ek);
        end
    endtask

    task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic load_slot(input int col, input logic [21:0] v, input logic [1:0] k);
        wr_byte(8'(8'h10 + col), v[21:14]);
        wr_byte(8'(8'h18 + col), v[13:6]);
        wr_byte(8'(8'h20 + col), {v[5:1], k[1], v[0], k[0]});
    endtask

    // Strobe one codeword, then sample one cycle later and check; also check the pulse ends.
    task automatic probe(input string tag, input logic [31:0] w, input logic eh,
                         input logic [2:0] ei, input logic [1:0] ek);
        @(negedge clk);
        cw_vld = 1'b1; cw_data = w;
        @(negedge clk);
        cw_vld = 1'b0;
        n_chk++;
        if (res_vld !== 1'b1) begin
            n_bad++;
            $display("FAIL R11 %s: res_vld got %0d want 1", tag, res_vld);
        end
        check(tag, res_hit, res_id, res_kind, eh, ei, ek);
        @(negedge clk);
        n_chk++;
        if (res_vld !== 1'b0) begin
            n_bad++;
            $display("FAIL R11 %s: res_vld pulse got %0d want 0", tag, res_vld);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: outputs cleared during reset
        n_chk++;
        if (res_vld !== 1'b0) begin
            n_bad++;
            $display("FAIL R12: res_vld got %0d want 0", res_vld);
        end
        check("R12 reset", res_hit, res_id, res_kind, 1'b0, 3'd0, 2'b00);
        rst_n = 1'b1;

        load_slot(0, PA, 2'b00);
        load_slot(1, PB, 2'b10);
        load_slot(2, PC, 2'b01);
        load_slot(3, PD, 2'b11);
        load_slot(4, PA, 2'b00);
        load_slot(5, PE, 2'b00);
        // R1: writes to unmapped addresses must not disturb the table
        wr_byte(8'h16, 8'hFF); wr_byte(8'h17, 8'hFF); wr_byte(8'h1E, 8'h00);
        wr_byte(8'h26, 8'hFF); wr_byte(8'h0F, 8'h00); wr_byte(8'h28, 8'hFF);

        for (int i = 0; i < NV; i++) begin
            en_batch0 = VEC[i][7];
            en_cont   = VEC[i][6];
            probe($sformatf("R1 vector %0d", i), VEC[i][39:8], VEC[i][5], VEC[i][4:2], VEC[i][1:0]);
        end

        en_batch0 = 1'b1; en_cont = 1'b1;
        // R10: slots 1 and 5 share a pattern; slot 1 wins
        probe("R10 lowest wins", {PA, 10'h0}, 1'b1, 3'd1, 2'b00);
        // R3: disable slot 1, slot 5 takes over
        slot_en = 6'b011110;
        probe("R3 slot1 off", {PA, 10'h0}, 1'b1, 3'd5, 2'b00);
        // R3: enable slot 6
        slot_en = 6'b111111;
        probe("R3 slot6 on", {PE, 10'h0}, 1'b1, 3'd6, 2'b00);
        // R10: slot 6 holding the sync pattern beats identifier 7
        load_slot(5, PS, 2'b00);
        probe("R10 slot beats sync", SYNC, 1'b1, 3'd6, 2'b00);
        // R6: slot 2 with forbidden kinds never matches
        load_slot(1, PB, 2'b11);
        probe("R6 slot2 kind11", {PB, 10'h0}, 1'b0, 3'd0, 2'b00);
        load_slot(1, PB, 2'b01);
        probe("R6 slot2 kind01", {PB, 10'h0}, 1'b0, 3'd0, 2'b00);
        // R6: slot 3 may carry continuous-data kind
        load_slot(2, PC, 2'b11);
        probe("R6 slot3 kind11", {PC, 10'h0}, 1'b1, 3'd3, 2'b11);
        // R1: rewriting row two of slot 1 alters only its middle byte
        wr_byte(8'h18, PE[13:6]);
        probe("R1 row2 rewrite", {PA[21:14], PE[13:6], PA[5:0], 10'h0}, 1'b1, 3'd1, 2'b00);

        // R12: reset clears the table
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        probe("R12 table cleared", {PA, 10'h0}, 1'b0, 3'd0, 2'b00);
        probe("R12 sync after reset", SYNC, 1'b1, 3'd7, 2'b01);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout want completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule